// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block turns one source clock into a group of gated copies that can be parked for power saving. An active-low stop request, which may change at any time relative to the source clock, is passed through a chain of rising-edge flops. The group then parks its outputs low at a clean boundary. When the request is withdrawn, the group resumes with a complete first high phase. Each output also has its own enable bit from a configuration register, and a disabled output stays low whatever the request says. A mode input decides whether stop requests are honoured at all. A free-running copy of the source clock is always provided and is never gated.

The block is meant to be placed once per clock group with different parameters. A fast processor-side group uses a two-flop synchronizer and a long minimum run time. A slower bus-side group uses a single flop and a short run time. After any restart, the group guarantees a minimum number of full clock pulses before a new stop can take effect. A stop that arrives inside that window is remembered and carried out as soon as the window closes.

Top module: `clk_stop_group`

## Requirements
- R1: While `rst_n` is 0, every `gclk` bit is 0. After reset the group is running and the minimum-run window counts as already expired, so a stop may take effect at once.
- R2: `stop_req_n` is sampled only on rising edges of `clk_src`, through SYNC_STAGES flops. A request that is 0 at exactly one rising edge suppresses exactly one pulse of the group, provided the window allows it.
- R3: Off latency: `stop_req_n` = 0 is first sampled at rising edge k with the window expired. Pulses still appear at edges k through k+SYNC_STAGES-1, and none appear from edge k+SYNC_STAGES onward.
- R4: On latency: `stop_req_n` = 1 is first sampled at rising edge k while the group is stopped. The first restored pulse begins at edge k+SYNC_STAGES.
- R5: A gated output changes its enable only while `clk_src` is low. Every high phase of a `gclk` bit is therefore a full half period, and every stop leaves the output at 0.
- R6: After a restart, the group emits at least MIN_RUN pulses before stopping. A synchronized stop that is still requested when the MIN_RUN-th pulse ends stops the group right after that pulse, with no further pulse.
- R7: With `mode_strap` = 1, stop requests are ignored and a stopped group restarts at the next falling edge. With `mode_strap` = 0, requests are honoured. The strap is applied after the synchronizer, so it takes effect at the next falling edge.
- R8: `out_en[i]` = 0 holds `gclk[i]` at 0 and `out_en[i]` = 1 lets it follow the group state. A change takes effect at the next falling edge of `clk_src`, so it is visible from the following high phase. The mask does not alter the group's run window.
- R9: `free_clk` equals `clk_src` at all times, including while the group is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock that the group gates |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous stop request, 0 asks the group to park |
| mode_strap | input | 1 | 0 honours stop requests, 1 keeps the group running |
| out_en | input | NUM_OUT | Per-output enable from configuration, 1 runs, 0 holds low |
| gclk | output | NUM_OUT | Gated clock outputs |
| free_clk | output | 1 | Ungated copy of `clk_src` |

## Verification
The bench goes after the latency edges of both parameter sets, which are exactly the number of pulses that slip out after a stop and the edge of the first pulse after a restart. A synchronizer that was one stage short or long would show up there as an extra or missing pulse. It then requests a stop right after a restart and counts pulses up to the window boundary: a design that dropped the pending stop would run forever, and one that counted the window wrongly would stop a pulse early or late. Mask changes, strap flips in both directions and a single-edge request round things off. High-phase widths are timed to catch a gate that switches while the clock is high and would leave a runt pulse.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // Width of a counter that must hold values 0 .. n-1.
  function automatic int cnt_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Group run decision taken on each falling edge.
  function automatic logic next_run(input logic go, input logic running, input logic window_over);
    return go | (running & ~window_over);
  endfunction
endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [STAGES-1:0] chain;

  // R2: request crosses into the clock domain only on rising edges
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/run_window.sv
module run_window
  import clk_stop_pkg::*;
#(
  parameter int MIN_RUN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  output logic run_q,
  output logic win_done
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CW = cnt_bits(MIN_RUN);
  localparam logic [CW-1:0] LAST = CW'(MIN_RUN - 1);

  logic [CW-1:0] cnt;
  logic          run_d;
  logic          restart;

  // cnt = pulses since restart minus one, saturating at LAST
  assign win_done = (cnt == LAST);
  assign run_d    = next_run(go_req, run_q, win_done);
  assign restart  = ~run_q & run_d;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      cnt   <= LAST;
    end else begin
      run_q <= run_d;
      if (restart)                cnt <= '0;
      else if (run_q && !win_done) cnt <= cnt + 1'b1;
    end
  end

  // R6
  stop_after_window_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(win_done));

  // R6
  window_restart_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt == '0));

  // R4
  go_restarts_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (go_req && !run_q) |=> run_q);
endmodule

// File: rtl/gate_bank.sv
module gate_bank #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] gclk
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [NUM_OUT-1:0] en_q;

  // R5: mask register updated on the falling edge, like the group state
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= out_en;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign gclk[i] = clk & run & en_q[i];

    // R8
    mask_holds_low_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !out_en[i] |=> !gclk[i]);
  end
endmodule

// File: rtl/clk_stop_group.sv
module clk_stop_group #(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic               stop_req_n,
  input  logic               mode_strap,
  input  logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] gclk,
  output logic               free_clk
);
  timeunit 1ns;
  timeprecision 100ps;

  logic sync_go;
  logic go_req;
  logic run_grp;
  logic win_done;

  stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_src),
    .rst_n(rst_n),
    .din  (stop_req_n),
    .dout (sync_go)
  );

  // R7: strap is static, applied after the synchronizer
  assign go_req = sync_go | mode_strap;

  run_window #(.MIN_RUN(MIN_RUN)) u_win (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .go_req  (go_req),
    .run_q   (run_grp),
    .win_done(win_done)
  );

  gate_bank #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk   (clk_src),
    .rst_n (rst_n),
    .run   (run_grp),
    .out_en(out_en),
    .gclk  (gclk)
  );

  // R9
  assign free_clk = clk_src;

  // R7
  strap_keeps_running_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
    mode_strap |=> run_grp);
endmodule

// File: tb/sim_clk_stop_group.sv
module sim_clk_stop_group;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N  = 4;
  localparam int S0 = 2;
  localparam int M0 = 100;
  localparam int S1 = 1;
  localparam int M1 = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_n = 1'b1;
  logic mode = 1'b0;
  logic [N-1:0] out_en = '1;
  logic [N-1:0] gc0, gc1;
  logic fc0, fc1;

  int vectors = 0;
  int miscmp = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  clk_stop_group #(.NUM_OUT(N), .SYNC_STAGES(S0), .MIN_RUN(M0)) u0 (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_n), .mode_strap(mode),
    .out_en(out_en), .gclk(gc0), .free_clk(fc0));

  clk_stop_group #(.NUM_OUT(N), .SYNC_STAGES(S1), .MIN_RUN(M1)) u1 (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_n), .mode_strap(mode),
    .out_en(out_en), .gclk(gc1), .free_clk(fc1));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $realtime);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic   hist [2][8];
  logic   m_run [2];
  int     m_pulses [2];
  logic [N-1:0] m_en;

  function automatic int stages_of(input int i);
    return (i == 0) ? S0 : S1;
  endfunction
  function automatic int minrun_of(input int i);
    return (i == 0) ? M0 : M1;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        for (int j = 0; j < 8; j++) hist[i][j] = 1'b1;
      end else begin
        for (int j = 7; j > 0; j--) hist[i][j] = hist[i][j-1];
        hist[i][0] = stop_n;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_run[i] = 1'b1;
        m_pulses[i] = minrun_of(i);
      end
      m_en = '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic go;
        go = hist[i][stages_of(i)-1] | mode;
        if (m_run[i]) m_pulses[i]++;
        if (go) begin
          if (!m_run[i]) m_pulses[i] = 0;
          m_run[i] = 1'b1;
        end else if (m_run[i] && m_pulses[i] >= minrun_of(i)) begin
          m_run[i] = 1'b0;
        end
      end
      m_en = out_en;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_run[i] = 1'b1;
      m_pulses[i] = 0;
      for (int j = 0; j < 8; j++) hist[i][j] = 1'b1;
    end
    m_en = '0;
  end

  // compare in the middle of each phase, every cycle
  always @(posedge clk) begin
    #1.5;
    chk(tag, "u0 gclk high phase", 32'(gc0), 32'(m_run[0] ? m_en : '0));
    chk(tag, "u1 gclk high phase", 32'(gc1), 32'(m_run[1] ? m_en : '0));
    chk("R9", "free_clk high phase", {30'd0, fc1, fc0}, 32'd3);
    #1.5;
    chk("R5", "gclk low phase", 32'({gc1, gc0}), 32'd0);
    chk("R9", "free_clk low phase", {30'd0, fc1, fc0}, 32'd0);
  end

  // R5: every high phase of a gated output is a full half period
  realtime r0 = 0.0, r1 = 0.0;
  always @(posedge gc0[0]) r0 = $realtime;
  always @(posedge gc1[0]) r1 = $realtime;
  always @(negedge gc0[0]) if (rst_n === 1'b1)
    chk("R5", "u0 high width ok", 32'(($realtime - r0) > 1.95 && ($realtime - r0) < 2.05), 32'd1);
  always @(negedge gc1[0]) if (rst_n === 1'b1)
    chk("R5", "u1 high width ok", 32'(($realtime - r1) > 1.95 && ($realtime - r1) < 2.05), 32'd1);

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic count_hi(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1.5;
      if (gc0[0]) c0++;
      if (gc1[0]) c1++;
    end
  endtask

  task automatic first_high(input int n, output int f0, output int f1);
    f0 = -1; f1 = -1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1.5;
      if (f0 < 0 && gc0[0]) f0 = i;
      if (f1 < 0 && gc1[0]) f1 = i;
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  initial begin
    #(4.0 * 20000);
    miscmp++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int c0, c1, f0, f1;
    tag = "R1";
    tick(3);
    chk("R1", "u0 gclk in reset", 32'(gc0), 32'd0);
    chk("R1", "u1 gclk in reset", 32'(gc1), 32'd0);
    rst_n = 1'b1;
    tick(5);
    chk("R1", "u0 running after reset", 32'(gc0), 32'hF);
    chk("R1", "u1 running after reset", 32'(gc1), 32'hF);

    // R3: off latency = SYNC_STAGES pulses after first sample
    tag = "R3";
    stop_n = 1'b0;
    count_hi(12, c0, c1);
    chk("R3", "u0 pulses after stop", 32'(c0), 32'(S0));
    chk("R3", "u1 pulses after stop", 32'(c1), 32'(S1));

    // R4: first pulse at edge k+SYNC_STAGES
    tag = "R4";
    tick(1);
    stop_n = 1'b1;
    first_high(10, f0, f1);
    chk("R4", "u0 first pulse index", 32'(f0), 32'(S0));
    chk("R4", "u1 first pulse index", 32'(f1), 32'(S1));

    // R6: pending stop inside the window; 9 (u0) and 10 (u1) pulses already out
    tag = "R6";
    tick(1);
    stop_n = 1'b0;
    count_hi(150, c0, c1);
    chk("R6", "u0 pulses to window end", 32'(c0), 32'(M0 - 9));
    chk("R6", "u1 pulses after expired window", 32'(c1), 32'(S1));

    // R7: strap 1 overrides the request
    tag = "R7";
    tick(1);
    mode = 1'b1;
    count_hi(30, c0, c1);
    chk("R7", "u0 runs with strap set", 32'(c0), 32'd30);
    chk("R7", "u1 runs with strap set", 32'(c1), 32'd30);
    tick(1);
    mode = 1'b0;
    count_hi(100, c0, c1);
    chk("R7", "u0 honours stop after window", 32'(c0), 32'(M0 - 31));
    chk("R7", "u1 stops at once on strap clear", 32'(c1), 32'd0);

    // R8: per-output mask
    tag = "R8";
    tick(1);
    stop_n = 1'b1;
    out_en = 4'b0101;
    tick(10);
    chk("R8", "u0 masked outputs", 32'(gc0), 32'h5);
    chk("R8", "u1 masked outputs", 32'(gc1), 32'h5);
    out_en = 4'b1000;
    tick(1);
    chk("R8", "u0 mask change next phase", 32'(gc0), 32'h8);
    chk("R8", "u1 mask change next phase", 32'(gc1), 32'h8);

    // R9: free clock follows the source
    tag = "R9";
    chk("R9", "free_clk high", {30'd0, fc1, fc0}, 32'd3);
    #2;
    chk("R9", "free_clk low", {30'd0, fc1, fc0}, 32'd0);

    // R2: one-edge request suppresses one pulse
    tag = "R2";
    out_en = 4'hF;
    tick(120);
    stop_n = 1'b0;
    tick(1);
    stop_n = 1'b1;
    count_hi(20, c0, c1);
    chk("R2", "u0 one pulse dropped", 32'(c0), 32'd19);
    chk("R2", "u1 one pulse dropped", 32'(c1), 32'd19);

    // mixed traffic, checked by the model every cycle
    tag = "R6";
    for (int k = 0; k < 3000; k++) begin
      tick(1);
      if ($urandom_range(19, 0) == 0)  stop_n = ~stop_n;
      if ($urandom_range(199, 0) == 0) mode = ~mode;
      if ($urandom_range(49, 0) == 0)  out_en = N'($urandom);
    end
    tick(4);
    finish_run();
  end
endmodule